// File: doc/BRIEF.md
# Serial Command Word Decoder

This block is the register front end of a small radio transmitter. A host writes 16-bit command words over a four-wire serial link with an active-low select. Each word begins with an opcode prefix that is 3, 4 or 8 bits long, and the prefix picks the register the rest of the word loads. All registers are presented as parallel outputs. They go to the synthesizer, the oscillator, the power stages and the timers, which lie outside this block.

Two commands do not follow the plain 16-bit write rule. The output-power command is a single byte. The transmit command streams data bytes after its opcode, and each complete byte goes out on a data port together with a one-cycle strobe.

A status-read opcode turns the interrupt output into a serial data line for the rest of the frame. It shifts out a snapshot of the pending event flags. When the select is released, it retires the highest-priority pending flag. Two values are corrected on the way in: a frequency word outside its legal range is dropped, and the unused deviation code is replaced by its nearest neighbour.

Top module: `spiCmdDecoder`

## Requirements
- R1: After reset the words read cfgWord=8080h, freqWord=A7D0h, wakeWord=E000h, txPwrByte=B0h, pwrWord=C000h, battWord=C200h, sleepWord=C400h, rateWord=C800h, buttonWord=CA00h and txData=00h, and irqN is 1.
- R2: The link inputs are synchronous to clk. sdi is sampled on each rising sck while csN is low, first bit being the MSB of the word. A frame of exactly 16 clocks whose bits 15:13 are 100 loads cfgWord bits 12:0. The fields are band 12:11, clock select 10:8, load-cap step 7:4, polarity 3 and deviation 2:0. A deviation of 111 is stored as 110.
- R3: A 16-clock frame with bits 15:12 = 1010 loads the 12-bit frequency field only if its value lies between 96 and 3903 inclusive. Any other value leaves freqWord unchanged.
- R4: A 16-clock frame with bits 15:13 = 111 loads the wake-period field: exponent in bits 12:8, multiplier in bits 7:0.
- R5: A 16-clock frame whose first byte is C0h, C2h, C4h, C8h or CAh loads its second byte into the low byte of pwrWord, battWord, sleepWord, rateWord or buttonWord respectively.
- R6: A frame of exactly 8 clocks with bits 7:4 = 1011 loads txPwrByte. OOK enable is bit 3 and the power step is bits 2:0. A frame of any other length with that prefix changes nothing.
- R7: A register is written only in the cycle after csN rises. A frame whose clock count is not the one its command needs (16, or 8 for R6) is discarded.
- R8: In a frame whose first byte is C6h, every complete 8-bit group after the opcode appears on txData with txStrobe high for one cycle. A trailing partial group produces no strobe.
- R9: In a frame whose first byte is CCh, irqN shows the status snapshot after the 8th clock. The snapshot is the pending flags, highest index first. Each later clock shifts out the next flag, and zeros follow the last one.
- R10: A high pulse on evtIn[i] sets pending flag i. Outside a status read, irqN is low exactly when some flag is pending. Releasing csN after a status read clears the lowest-index pending flag.
- R11: Frames whose first byte has prefix 110 but is not a listed opcode (for example CEh) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select |
| sck | input | 1 | Serial bit clock, sampled by clk |
| sdi | input | 1 | Serial data in, MSB first |
| evtIn | input | 4 | Interrupt event pulses, one per source |
| irqN | output | 1 | Active-low interrupt, or serial status during a status read |
| cfgWord | output | 16 | Configuration word |
| freqWord | output | 16 | Frequency word |
| wakeWord | output | 16 | Wake period word |
| txPwrByte | output | 8 | Output power byte |
| pwrWord | output | 16 | Power management word |
| battWord | output | 16 | Battery threshold and bit sync word |
| sleepWord | output | 16 | Sleep and clock hold-off word |
| rateWord | output | 16 | Data rate word |
| buttonWord | output | 16 | Button control word |
| txData | output | 8 | Last streamed transmit byte |
| txStrobe | output | 1 | One-cycle pulse per streamed byte |

## Verification
Writes are sent with each prefix length. For 16-bit frames the test tells apart 3-bit, 4-bit and 8-bit decodes that share leading ones. Frames of 7, 8, 15, 16 and 17 clocks show that the clock count, not the prefix alone, decides a commit. Frequency values at 95, 96, 3903 and 3904 pin down both range edges. A streamed transmit frame with a ragged tail separates whole bytes from partial ones. Two back-to-back status reads with two flags pending show the shift order and that only the lowest flag is retired per read.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int FREQ_W = WORD_W - 4;

  // strobes from the frame control to the datapath
  typedef struct packed {
    logic shift;      // a bit was sampled
    logic opReady;    // the 8th bit of the frame was sampled
    logic byteReady;  // a full data byte after the opcode was sampled
    logic commit8;    // frame closed after exactly 8 bits
    logic commit16;   // frame closed after exactly 16 bits
    logic frameClose; // select released
  } ctrlStrobe_t;

  localparam int NUM_BYTE_REGS = 5;
  // order: power, battery, sleep, rate, button
  localparam logic [NUM_BYTE_REGS*BYTE_W-1:0] BYTE_OPS =
    {8'hCA, 8'hC8, 8'hC4, 8'hC2, 8'hC0};
  localparam logic [BYTE_W-1:0] OP_TXSTREAM = 8'hC6;
  localparam logic [BYTE_W-1:0] OP_STATUS   = 8'hCC;

  localparam logic [2:0] PFX_CFG   = 3'b100;
  localparam logic [2:0] PFX_WAKE  = 3'b111;
  localparam logic [3:0] PFX_FREQ  = 4'hA;
  localparam logic [3:0] PFX_TXPWR = 4'hB;

  localparam logic [12:0] CFG_RST  = 13'h0080;
  localparam logic [FREQ_W-1:0] FREQ_RST = 12'h7D0;
  localparam logic [12:0] WAKE_RST = 13'h0000;
endpackage

// File: rtl/spiFrameCtrl.sv
module spiFrameCtrl
  import spiCmdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  output ctrlStrobe_t strobe
);
  localparam int SAT_VAL = 2 * BYTE_W + 1;
  localparam int CNT_W   = $clog2(SAT_VAL + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SAT_VAL);
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_8    = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_16   = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(2 * BYTE_W - 1);

  logic sckQ, csQ;
  logic [CNT_W-1:0] frameBits;
  logic [2:0] bitInByte;
  logic sckRise, csRise;

  assign sckRise = sck & ~sckQ & ~csN;
  assign csRise  = csN & ~csQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ      <= 1'b0;
      csQ       <= 1'b1;
      frameBits <= '0;
      bitInByte <= '0;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
      if (csN) begin
        frameBits <= '0;
        bitInByte <= '0;
      end else if (sckRise) begin
        if (frameBits != CNT_SAT) frameBits <= frameBits + 1'b1;
        bitInByte <= bitInByte + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.shift      = sckRise;
    strobe.opReady    = sckRise && (frameBits == CNT_OP);
    strobe.byteReady  = sckRise && (bitInByte == 3'd7) && (frameBits >= CNT_DATA);
    strobe.commit8    = csRise && (frameBits == CNT_8);
    strobe.commit16   = csRise && (frameBits == CNT_16);
    strobe.frameClose = csRise;
  end
endmodule

// File: rtl/spiCmdDatapath.sv
module spiCmdDatapath
  import spiCmdPkg::*;
#(
  parameter int STAT_W   = 4,
  parameter int FREQ_MIN = 96,
  parameter int FREQ_MAX = 3903
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  ctrlStrobe_t       strobe,
  input  logic [STAT_W-1:0] evtIn,
  output logic [WORD_W-1:0] cfgWord,
  output logic [WORD_W-1:0] freqWord,
  output logic [WORD_W-1:0] wakeWord,
  output logic [BYTE_W-1:0] txPwrByte,
  output logic [WORD_W-1:0] pwrWord,
  output logic [WORD_W-1:0] battWord,
  output logic [WORD_W-1:0] sleepWord,
  output logic [WORD_W-1:0] rateWord,
  output logic [WORD_W-1:0] buttonWord,
  output logic [BYTE_W-1:0] txData,
  output logic              txStrobe,
  output logic              irqN
);
  localparam logic [FREQ_W-1:0] F_LO = FREQ_W'(FREQ_MIN);
  localparam logic [FREQ_W-1:0] F_HI = FREQ_W'(FREQ_MAX);

  logic [WORD_W-1:0] shiftWord, nextWord;
  logic [BYTE_W-1:0] opByte;
  logic [12:0] cfgData, wakeData;
  logic [FREQ_W-1:0] freqData, freqCand;
  logic [3:0] pwrNib;
  logic freqOk;
  logic [2:0] devFixed;

  assign nextWord = {shiftWord[WORD_W-2:0], sdi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
      opByte    <= '0;
    end else begin
      if (strobe.shift)   shiftWord <= nextWord;
      if (strobe.opReady) opByte    <= nextWord[BYTE_W-1:0];
    end
  end

  // wide-prefix registers
  assign freqCand = shiftWord[FREQ_W-1:0];
  assign freqOk   = (freqCand >= F_LO) && (freqCand <= F_HI);
  assign devFixed = (shiftWord[2:0] == 3'b111) ? 3'b110 : shiftWord[2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgData  <= CFG_RST;
      freqData <= FREQ_RST;
      wakeData <= WAKE_RST;
      pwrNib   <= '0;
    end else begin
      if (strobe.commit16) begin
        if (shiftWord[15:13] == PFX_CFG)
          cfgData <= {shiftWord[12:3], devFixed};
        if (shiftWord[15:12] == PFX_FREQ && freqOk)
          freqData <= freqCand;
        if (shiftWord[15:13] == PFX_WAKE)
          wakeData <= shiftWord[12:0];
      end
      if (strobe.commit8 && shiftWord[7:4] == PFX_TXPWR)
        pwrNib <= shiftWord[3:0];
    end
  end

  assign cfgWord   = {PFX_CFG, cfgData};
  assign freqWord  = {PFX_FREQ, freqData};
  assign wakeWord  = {PFX_WAKE, wakeData};
  assign txPwrByte = {PFX_TXPWR, pwrNib};

  // byte-opcode registers
  logic [WORD_W-1:0] byteWords [NUM_BYTE_REGS];

  for (genvar i = 0; i < NUM_BYTE_REGS; i++) begin : g_byteReg
    localparam logic [BYTE_W-1:0] OPC = BYTE_OPS[i*BYTE_W +: BYTE_W];
    logic [BYTE_W-1:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) val <= '0;
      else if (strobe.commit16 && shiftWord[15:8] == OPC) val <= shiftWord[7:0];
    end
    assign byteWords[i] = {OPC, val};
  end

  assign pwrWord    = byteWords[0];
  assign battWord   = byteWords[1];
  assign sleepWord  = byteWords[2];
  assign rateWord   = byteWords[3];
  assign buttonWord = byteWords[4];

  // transmit byte stream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData   <= '0;
      txStrobe <= 1'b0;
    end else if (strobe.byteReady && opByte == OP_TXSTREAM) begin
      txData   <= nextWord[BYTE_W-1:0];
      txStrobe <= 1'b1;
    end else begin
      txStrobe <= 1'b0;
    end
  end

  // pending flags and status shifter
  logic [STAT_W-1:0] pending, statShift, lowestMask, clearMask;
  logic statActive;

  assign lowestMask = pending & (~pending + 1'b1);
  assign clearMask  = (strobe.frameClose && statActive) ? lowestMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending    <= '0;
      statShift  <= '0;
      statActive <= 1'b0;
    end else begin
      pending <= (pending & ~clearMask) | evtIn;
      if (strobe.frameClose) begin
        statActive <= 1'b0;
      end else if (strobe.opReady && nextWord[BYTE_W-1:0] == OP_STATUS) begin
        statActive <= 1'b1;
        statShift  <= pending;
      end else if (strobe.shift && statActive) begin
        statShift <= {statShift[STAT_W-2:0], 1'b0};
      end
    end
  end

  assign irqN = statActive ? statShift[STAT_W-1] : ~|pending;
endmodule

// File: rtl/spiCmdDecoder.sv
module spiCmdDecoder
  import spiCmdPkg::*;
#(
  parameter int STAT_W   = 4,
  parameter int FREQ_MIN = 96,
  parameter int FREQ_MAX = 3903
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  input  logic [STAT_W-1:0] evtIn,
  output logic              irqN,
  output logic [15:0]       cfgWord,
  output logic [15:0]       freqWord,
  output logic [15:0]       wakeWord,
  output logic [7:0]        txPwrByte,
  output logic [15:0]       pwrWord,
  output logic [15:0]       battWord,
  output logic [15:0]       sleepWord,
  output logic [15:0]       rateWord,
  output logic [15:0]       buttonWord,
  output logic [7:0]        txData,
  output logic              txStrobe
);
  ctrlStrobe_t strobe;

  spiFrameCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .strobe(strobe)
  );

  spiCmdDatapath #(
    .STAT_W(STAT_W), .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX)
  ) data_i (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strobe(strobe), .evtIn(evtIn),
    .cfgWord(cfgWord), .freqWord(freqWord), .wakeWord(wakeWord),
    .txPwrByte(txPwrByte), .pwrWord(pwrWord), .battWord(battWord),
    .sleepWord(sleepWord), .rateWord(rateWord), .buttonWord(buttonWord),
    .txData(txData), .txStrobe(txStrobe), .irqN(irqN)
  );
endmodule

// File: rtl/spiCmdDecoderChecker.sv
module spiCmdDecoderChecker #(
  parameter int FREQ_MIN = 96,
  parameter int FREQ_MAX = 3903
) (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic [15:0] cfgWord,
  input logic [15:0] freqWord,
  input logic [15:0] wakeWord,
  input logic        txStrobe
);
  localparam logic [11:0] F_LO = 12'(FREQ_MIN);
  localparam logic [11:0] F_HI = 12'(FREQ_MAX);

  p_freq_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (freqWord[11:0] >= F_LO) && (freqWord[11:0] <= F_HI));

  p_dev_code_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWord[2:0] != 3'b111);

  p_hold_while_selected_r7: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> ($stable(freqWord) && $stable(cfgWord) && $stable(wakeWord)));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |=> !txStrobe);
endmodule

bind spiCmdDecoder spiCmdDecoderChecker #(
  .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX)
) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .cfgWord(cfgWord), .freqWord(freqWord),
  .wakeWord(wakeWord), .txStrobe(txStrobe)
);

// File: tb/spiCmdDecoder_tb_top.sv
module spiCmdDecoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAT_W = 4;

  logic clk = 1'b0;
  logic rstN, csN, sck, sdi;
  logic [STAT_W-1:0] evtIn;
  logic irqN, txStrobe;
  logic [15:0] cfgWord, freqWord, wakeWord, pwrWord, battWord, sleepWord, rateWord, buttonWord;
  logic [7:0] txPwrByte, txData;

  spiCmdDecoder dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi), .evtIn(evtIn),
    .irqN(irqN), .cfgWord(cfgWord), .freqWord(freqWord), .wakeWord(wakeWord),
    .txPwrByte(txPwrByte), .pwrWord(pwrWord), .battWord(battWord),
    .sleepWord(sleepWord), .rateWord(rateWord), .buttonWord(buttonWord),
    .txData(txData), .txStrobe(txStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t scoreQ[$];
  logic [7:0] txExpQ[$];
  int checks = 0;
  int errors = 0;

  function automatic logic [15:0] portVal(input int sel);
    case (sel)
      0: return cfgWord;
      1: return freqWord;
      2: return wakeWord;
      3: return {8'h00, txPwrByte};
      4: return pwrWord;
      5: return battWord;
      6: return sleepWord;
      7: return rateWord;
      8: return buttonWord;
      9: return {15'b0, irqN};
      default: return {8'h00, txData};
    endcase
  endfunction

  // monitor: compares queued expectations and streamed bytes
  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      item_t it;
      it = scoreQ.pop_front();
      checks++;
      if (portVal(it.sel) !== it.exp) begin
        errors++;
        $display("FAIL %s port %0d actual %h expected %h", it.req, it.sel, portVal(it.sel), it.exp);
      end
    end
    if (rstN === 1'b1 && txStrobe === 1'b1) begin
      checks++;
      if (txExpQ.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected strobe actual %h expected none", txData);
      end else begin
        logic [7:0] e;
        e = txExpQ.pop_front();
        if (txData !== e) begin
          errors++;
          $display("FAIL R8 streamed byte actual %h expected %h", txData, e);
        end
      end
    end
  end

  task automatic checkPort(input int sel, input logic [15:0] v, input string req);
    scoreQ.push_back('{sel, v, req});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clockBit(input logic b);
    sdi = b;
    @(negedge clk);
    sck = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic startFrame;
    csN = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic endFrame;
    csN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] bits, input int n);
    startFrame();
    for (int i = n - 1; i >= 0; i--) clockBit(bits[i]);
    endFrame();
  endtask

  task automatic pulseEvt(input logic [STAT_W-1:0] v);
    evtIn = v;
    @(negedge clk);
    evtIn = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; sdi = 1'b0; evtIn = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    checkPort(0, 16'h8080, "R1");
    checkPort(1, 16'hA7D0, "R1");
    checkPort(2, 16'hE000, "R1");
    checkPort(3, 16'h00B0, "R1");
    checkPort(4, 16'hC000, "R1");
    checkPort(5, 16'hC200, "R1");
    checkPort(6, 16'hC400, "R1");
    checkPort(7, 16'hC800, "R1");
    checkPort(8, 16'hCA00, "R1");
    checkPort(9, 16'h0001, "R1");
    checkPort(10, 16'h0000, "R1");

    // R2 configuration writes and deviation fix
    xfer(32'h935A, 16);
    checkPort(0, 16'h935A, "R2");
    xfer(32'h8F1F, 16);
    checkPort(0, 16'h8F1E, "R2 dev");

    // R3 frequency range edges
    xfer(32'hA060, 16); checkPort(1, 16'hA060, "R3 min");
    xfer(32'hA05F, 16); checkPort(1, 16'hA060, "R3 below");
    xfer(32'hAF3F, 16); checkPort(1, 16'hAF3F, "R3 max");
    xfer(32'hAF40, 16); checkPort(1, 16'hAF3F, "R3 above");
    xfer(32'hA5A5, 16); checkPort(1, 16'hA5A5, "R3 mid");

    // R4 wake period
    xfer(32'hE123, 16); checkPort(2, 16'hE123, "R4");
    xfer(32'hFFFF, 16); checkPort(2, 16'hFFFF, "R4");

    // R5 byte opcodes
    xfer(32'hC05A, 16); checkPort(4, 16'hC05A, "R5");
    xfer(32'hC281, 16); checkPort(5, 16'hC281, "R5");
    xfer(32'hC464, 16); checkPort(6, 16'hC464, "R5");
    xfer(32'hC823, 16); checkPort(7, 16'hC823, "R5");
    xfer(32'hCA1E, 16); checkPort(8, 16'hCA1E, "R5");

    // R6 single-byte power command
    xfer(32'hB5, 8);   checkPort(3, 16'h00B5, "R6");
    xfer(32'hB37C, 16); checkPort(3, 16'h00B5, "R6 long");
    xfer(32'h59, 7);   checkPort(3, 16'h00B5, "R6 short");

    // R7 wrong clock counts and commit timing
    xfer(32'h4091, 15);  checkPort(0, 16'h8F1E, "R7 15");
    xfer(32'h10247, 17); checkPort(0, 16'h8F1E, "R7 17");
    startFrame();
    for (int i = 15; i >= 0; i--) clockBit(1'(16'hA123 >> i));
    checkPort(1, 16'hA5A5, "R7 before release");
    endFrame();
    checkPort(1, 16'hA123, "R7 after release");

    // R11 undefined byte opcode
    xfer(32'hCE55, 16);
    checkPort(4, 16'hC05A, "R11");
    checkPort(5, 16'hC281, "R11");
    checkPort(6, 16'hC464, "R11");
    checkPort(7, 16'hC823, "R11");
    checkPort(8, 16'hCA1E, "R11");

    // R8 transmit stream with partial tail
    txExpQ.push_back(8'hA5);
    txExpQ.push_back(8'h3C);
    xfer(32'hC6A53CA, 28);
    checks++;
    if (txExpQ.size() != 0) begin
      errors++;
      $display("FAIL R8 bytes left actual %0d expected 0", txExpQ.size());
    end
    checkPort(10, 16'h003C, "R8");

    // R10 events and idle interrupt
    pulseEvt(4'b1010);
    checkPort(9, 16'h0000, "R10 pending");

    // R9 status read one
    startFrame();
    for (int i = 7; i >= 0; i--) clockBit(1'(8'hCC >> i));
    checkPort(9, 16'h0001, "R9 bit3");
    clockBit(1'b0); checkPort(9, 16'h0000, "R9 bit2");
    clockBit(1'b0); checkPort(9, 16'h0001, "R9 bit1");
    clockBit(1'b0); checkPort(9, 16'h0000, "R9 bit0");
    clockBit(1'b0); checkPort(9, 16'h0000, "R9 fill");
    endFrame();
    checkPort(9, 16'h0000, "R10 one left");

    // status read two
    startFrame();
    for (int i = 7; i >= 0; i--) clockBit(1'(8'hCC >> i));
    checkPort(9, 16'h0001, "R9 second bit3");
    clockBit(1'b0); checkPort(9, 16'h0000, "R9 second bit2");
    endFrame();
    checkPort(9, 16'h0001, "R10 all cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule